// File: doc/BRIEF.md
# Dual Reference Switchover Controller

This block watches two reference clock inputs, A and B, from a local oscillator clock domain and decides which of them feeds a downstream phase detector. Each reference has its own activity monitor: the input is brought into the oscillator domain through a synchroniser, rising edges are detected, and a gap counter declares the reference lost when the edges stop for longer than a programmable window. A lost reference must then show a run of consecutive in-window edges before it counts as valid again.

A selection state machine uses the two validity flags. In manual mode a control bit picks the reference directly. In automatic mode the machine moves away from a failed reference. If the revertive option is set, it also moves back to the preferred reference once that reference is valid. When neither reference is valid, it parks in holdover. Every change of selection, and every exit from holdover, gives a single-cycle pulse so that downstream logic can realign.

Top module: `refsel_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, `sel_b` is 0 (reference A), `holdover` is 0, `switch_pulse` is 0 and both status flags `ref_a_ok`/`ref_b_ok` are 0.
- R2: A valid reference whose rising edges come closer together than the window stays valid. It becomes lost (status 0) when no rising edge is seen for a full window of oscillator cycles. The status flag changes no more than a few cycles after the window expires.
- R3: A lost reference becomes valid again only on the 64th consecutive rising edge in which each edge falls within the window. A window expiry restarts that count.
- R4: A `win_len` value below 16 is treated as 16. The largest window is 4095 cycles.
- R5: With `auto_mode`=0, `sel_b` follows `manual_b` (1 selects B) and `holdover` stays 0. Reference loss then changes only the status flags.
- R6: With `auto_mode`=1, if the selected reference is lost while the other one is valid, the selection moves to the other reference.
- R7: With `auto_mode`=1, when both references are invalid, `holdover` is 1 and `sel_b` keeps its last value.
- R8: On leaving holdover, the preferred reference (`prefer_b`=1 means B) is chosen if it is valid; otherwise the other one is chosen.
- R9: With `auto_mode`=1 and `revertive`=1, a valid selected reference that is not the preferred one is abandoned for the preferred one as soon as the preferred one is valid.
- R10: With `auto_mode`=1 and `revertive`=0, a valid selected reference is kept even when the preferred reference is valid.
- R11: `switch_pulse` is high for exactly one cycle for every change of `sel_b` and for every exit from holdover, and it is low otherwise.
- R12: Loss detection runs separately for each reference. Activity on one input never changes the other input's status flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_a | input | 1 | Reference A activity input (asynchronous) |
| ref_b | input | 1 | Reference B activity input (asynchronous) |
| win_len | input | 12 | Loss window in oscillator cycles (values below 16 act as 16) |
| auto_mode | input | 1 | 1 = automatic selection, 0 = manual selection |
| revertive | input | 1 | In automatic mode, return to the preferred reference |
| prefer_b | input | 1 | Preferred reference: 0 = A, 1 = B |
| manual_b | input | 1 | Manual choice: 0 = A, 1 = B |
| sel_b | output | 1 | Selected reference: 0 = A, 1 = B |
| holdover | output | 1 | No valid reference in automatic mode |
| ref_a_ok | output | 1 | Reference A valid |
| ref_b_ok | output | 1 | Reference B valid |
| switch_pulse | output | 1 | One-cycle realignment pulse |

## Verification
An edge on a reference input reaches the edge detector after two synchroniser flops. The status flag is registered one cycle after that, so it reacts three oscillator cycles after the input, and the selection, holdover and pulse registers react one cycle later still. Loss is declared one window after the last rising edge. Recovery completes on the 64th edge, which with the bench's reference periods takes up to about 1550 cycles. The bench therefore samples at falling clock edges only after a settling interval longer than the worst case for the stimulus just applied: 80 cycles after a reference stops, 1800 after it starts, and 10 after a control bit changes. The directed boundary checks for R2 and R3 are placed at points that stay clear of these latencies in both directions. Pulses are counted continuously and compared with the selection and holdover changes seen in the same interval.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
   localparam int NREF = 2;

   typedef enum logic [1:0] {
      ST_USE_A = 2'd0,
      ST_USE_B = 2'd1,
      ST_HOLD  = 2'd2
   } sel_state_t;
endpackage

// File: rtl/refsel_mon.sv
module refsel_mon #(
   parameter int WIN_W   = 12,
   parameter int MIN_WIN = 16,
   parameter int RECOV   = 64,
   parameter int SYNC    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_in,
   input  logic [WIN_W-1:0] win_len,
   output logic             ok
);
   localparam int CW = $clog2(RECOV + 1);
   localparam logic [WIN_W-1:0] MIN_V = WIN_W'(MIN_WIN);
   localparam logic [CW-1:0]    LAST_EDGE = CW'(RECOV - 1);

   generate
      if (SYNC < 2) begin : g_bad_sync
         $error("refsel_mon: SYNC must be at least 2");
      end
      if (RECOV < 1) begin : g_bad_recov
         $error("refsel_mon: RECOV must be at least 1");
      end
      if (MIN_WIN < 2 || MIN_WIN >= (1 << WIN_W)) begin : g_bad_win
         $error("refsel_mon: MIN_WIN out of range for WIN_W");
      end
   endgenerate

   logic [SYNC-1:0]  sync_q;
   logic             prev_q;
   logic             edge_p;
   logic [WIN_W-1:0] eff_win;
   logic [WIN_W-1:0] gap_q;
   logic             timeout;
   logic [CW-1:0]    good_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC-2:0], ref_in};
         prev_q <= sync_q[SYNC-1];
      end
   end

   assign edge_p  = sync_q[SYNC-1] & ~prev_q;
   assign eff_win = (win_len < MIN_V) ? MIN_V : win_len;
   assign timeout = !edge_p && (gap_q >= eff_win - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q <= '0;
      end else if (edge_p) begin
         gap_q <= '0;
      end else if (gap_q != '1) begin
         gap_q <= gap_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ok     <= 1'b0;
         good_q <= '0;
      end else if (timeout) begin
         ok     <= 1'b0;
         good_q <= '0;
      end else if (edge_p && !ok) begin
         if (good_q == LAST_EDGE) begin
            ok     <= 1'b1;
            good_q <= '0;
         end else begin
            good_q <= good_q + 1'b1;
         end
      end
   end

   // R3: validity is only ever regained on a detected edge
   a_r3_rise_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ok) |-> $past(edge_p));

   // R2: an edge inside the window never causes a loss in the next cycle
   a_r2_edge_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      edge_p |=> !$fell(ok));
endmodule

// File: rtl/refsel_fsm.sv
module refsel_fsm
   import refsel_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NREF-1:0] valid,
   input  logic            auto_mode,
   input  logic            revertive,
   input  logic            prefer_b,
   input  logic            manual_b,
   output logic            sel_b,
   output logic            holdover,
   output logic            switch_pulse
);
   sel_state_t state_q, state_n;
   logic       sel_q, sel_n, pulse_n;
   logic       cur;

   function automatic sel_state_t pick(input logic b);
      return b ? ST_USE_B : ST_USE_A;
   endfunction

   always_comb begin
      state_n = state_q;
      cur     = (state_q == ST_USE_B);
      if (!auto_mode) begin
         state_n = pick(manual_b);
      end else if (state_q == ST_HOLD) begin
         if (valid[prefer_b])       state_n = pick(prefer_b);
         else if (valid[!prefer_b]) state_n = pick(!prefer_b);
      end else if (!valid[cur]) begin
         state_n = valid[!cur] ? pick(!cur) : ST_HOLD;
      end else if (revertive && (cur != prefer_b) && valid[prefer_b]) begin
         state_n = pick(prefer_b);
      end
      sel_n   = (state_n == ST_HOLD) ? sel_q : (state_n == ST_USE_B);
      pulse_n = (sel_n != sel_q) || (state_q == ST_HOLD && state_n != ST_HOLD);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_USE_A;
         sel_q        <= 1'b0;
         switch_pulse <= 1'b0;
      end else begin
         state_q      <= state_n;
         sel_q        <= sel_n;
         switch_pulse <= pulse_n;
      end
   end

   assign sel_b    = sel_q;
   assign holdover = (state_q == ST_HOLD);

   // R5: manual mode follows the manual bit, never in holdover
   a_r5_manual_follow: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_mode |=> (sel_b == $past(manual_b)) && !holdover);

   // R7: holdover only arises from automatic operation
   a_r7_hold_auto: assert property (@(posedge clk) disable iff (!rst_n)
      holdover |-> $past(auto_mode));

   // R6: outside holdover, automatic mode only lands on a valid reference
   a_r6_sel_valid: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(auto_mode) && !holdover) |->
         (sel_b ? $past(valid[1]) : $past(valid[0])));
endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
   import refsel_pkg::*;
#(
   parameter int WIN_W   = 12,
   parameter int MIN_WIN = 16,
   parameter int RECOV   = 64,
   parameter int SYNC    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_a,
   input  logic             ref_b,
   input  logic [WIN_W-1:0] win_len,
   input  logic             auto_mode,
   input  logic             revertive,
   input  logic             prefer_b,
   input  logic             manual_b,
   output logic             sel_b,
   output logic             holdover,
   output logic             ref_a_ok,
   output logic             ref_b_ok,
   output logic             switch_pulse
);
   logic [NREF-1:0] refs;
   logic [NREF-1:0] valid;

   assign refs = {ref_b, ref_a};

   generate
      for (genvar i = 0; i < NREF; i++) begin : g_mon
         refsel_mon #(
            .WIN_W  (WIN_W),
            .MIN_WIN(MIN_WIN),
            .RECOV  (RECOV),
            .SYNC   (SYNC)
         ) u_mon (
            .clk    (clk),
            .rst_n  (rst_n),
            .ref_in (refs[i]),
            .win_len(win_len),
            .ok     (valid[i])
         );
      end
   endgenerate

   refsel_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .valid       (valid),
      .auto_mode   (auto_mode),
      .revertive   (revertive),
      .prefer_b    (prefer_b),
      .manual_b    (manual_b),
      .sel_b       (sel_b),
      .holdover    (holdover),
      .switch_pulse(switch_pulse)
   );

   assign ref_a_ok = valid[0];
   assign ref_b_ok = valid[1];

   // R11: every change of selection is accompanied by a pulse
   a_r11_pulse_on_switch: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_b != $past(sel_b)) |-> switch_pulse);

   // R11: every exit from holdover is accompanied by a pulse
   a_r11_pulse_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(holdover) |-> switch_pulse);
endmodule

// File: tb/sim_refsel_ctrl.sv
`timescale 1ns/1ps
module sim_refsel_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_a = 1'b0, ref_b = 1'b0;
   logic [11:0] win_len = 12'd40;
   logic        auto_mode = 1'b1, revertive = 1'b0, prefer_b = 1'b0, manual_b = 1'b0;
   logic        sel_b, holdover, ref_a_ok, ref_b_ok, switch_pulse;

   int n_checks = 0, n_fail = 0;
   bit done = 1'b0;

   logic on_a = 1'b0, on_b = 1'b0;
   int   hp_a = 25, hp_b = 35;

   // expected state
   logic e_sel = 1'b0, e_hold = 1'b0, e_va = 1'b0, e_vb = 1'b0;
   int   n_pulse = 0, n_event = 0;
   logic p_sel = 1'b0, p_hold = 1'b0;

   always #2.5 clk = ~clk;

   refsel_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .ref_a(ref_a), .ref_b(ref_b), .win_len(win_len),
      .auto_mode(auto_mode), .revertive(revertive), .prefer_b(prefer_b),
      .manual_b(manual_b), .sel_b(sel_b), .holdover(holdover),
      .ref_a_ok(ref_a_ok), .ref_b_ok(ref_b_ok), .switch_pulse(switch_pulse)
   );

   initial forever begin
      if (on_a) begin #(hp_a); ref_a = ~ref_a; end
      else begin ref_a = 1'b0; #5; end
   end
   initial forever begin
      if (on_b) begin #(hp_b); ref_b = ~ref_b; end
      else begin ref_b = 1'b0; #5; end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (switch_pulse) n_pulse++;
         if ((sel_b != p_sel) || (p_hold && !holdover)) n_event++;
      end
      p_sel  = sel_b;
      p_hold = holdover;
   end

   task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // reference selection model, iterated to its fixed point
   function automatic void model();
      logic pb, cur;
      logic [1:0] v;
      v = {e_vb, e_va};
      pb = prefer_b;
      for (int k = 0; k < 3; k++) begin
         if (!auto_mode) begin
            e_sel = manual_b; e_hold = 1'b0;
         end else if (e_hold) begin
            if (v[pb])       begin e_sel = pb;  e_hold = 1'b0; end
            else if (v[!pb]) begin e_sel = !pb; e_hold = 1'b0; end
         end else begin
            cur = e_sel;
            if (!v[cur]) begin
               if (v[!cur]) e_sel = !cur;
               else e_hold = 1'b1;
            end else if (revertive && cur != pb && v[pb]) begin
               e_sel = pb;
            end
         end
      end
   endfunction

   task automatic check_all(input string tag);
      chk("R12 status A", 12'(ref_a_ok), 12'(e_va));
      chk("R12 status B", 12'(ref_b_ok), 12'(e_vb));
      chk({tag, " sel"}, 12'(sel_b), 12'(e_sel));
      chk({tag, " hold"}, 12'(holdover), 12'(e_hold));
      chk("R11 pulse count", 12'(n_pulse), 12'(n_event));
      n_pulse = 0; n_event = 0;
   endtask

   task automatic set_ref(input bit is_b, input bit on);
      if (is_b) begin
         if (on) hp_b = $urandom_range(20, 60);
         on_b = on;
      end else begin
         if (on) hp_a = $urandom_range(20, 60);
         on_a = on;
      end
      cyc(on ? 1800 : 80);
      if (is_b) e_vb = on; else e_va = on;
      model();
   endtask

   initial begin
      void'($urandom(32'd20240611));
      cyc(5);
      chk("R1 sel", 12'(sel_b), 12'd0);
      chk("R1 hold", 12'(holdover), 12'd0);
      chk("R1 okA", 12'(ref_a_ok), 12'd0);
      chk("R1 okB", 12'(ref_b_ok), 12'd0);
      chk("R1 pulse", 12'(switch_pulse), 12'd0);
      rst_n = 1'b1;
      cyc(1);
      chk("R1 sel after release", 12'(sel_b), 12'd0);
      cyc(10);
      model();
      check_all("R7");

      // R4: window 5 acts as 16; period of 12 cycles survives
      win_len = 12'd5;
      hp_a = 30; on_a = 1'b1;
      cyc(1200);
      chk("R4 clamp keeps A", 12'(ref_a_ok), 12'd1);
      e_va = 1'b1; model();
      check_all("R8");
      win_len = 12'd40;

      // R2: loss timing with a 10-cycle period
      hp_a = 25;
      cyc(100);
      on_a = 1'b0;
      cyc(25);
      chk("R2 still valid inside window", 12'(ref_a_ok), 12'd1);
      cyc(30);
      chk("R2 lost after window", 12'(ref_a_ok), 12'd0);
      cyc(30);
      e_va = 1'b0; model();
      check_all("R7");

      // R3: 64 edges needed
      hp_a = 25; on_a = 1'b1;
      cyc(580);
      chk("R3 not valid before 64 edges", 12'(ref_a_ok), 12'd0);
      cyc(150);
      chk("R3 valid after 64 edges", 12'(ref_a_ok), 12'd1);
      cyc(20);
      e_va = 1'b1; model();
      check_all("R8");

      // R10 / R6 / R9 / R7 directed
      set_ref(1'b1, 1'b1); check_all("R10");
      set_ref(1'b0, 1'b0); check_all("R6");
      chk("R6 moved to B", 12'(sel_b), 12'd1);
      set_ref(1'b0, 1'b1); check_all("R10");
      chk("R10 stays on B", 12'(sel_b), 12'd1);
      revertive = 1'b1; cyc(10); model(); check_all("R9");
      chk("R9 back on A", 12'(sel_b), 12'd0);
      set_ref(1'b0, 1'b0); check_all("R6");
      set_ref(1'b1, 1'b0); check_all("R7");
      chk("R7 holdover, keeps B", 12'({holdover, sel_b}), 12'd3);
      prefer_b = 1'b1; cyc(10); model();
      set_ref(1'b0, 1'b1); check_all("R8");
      chk("R8 other chosen", 12'(sel_b), 12'd0);

      // R5 manual
      auto_mode = 1'b0; manual_b = 1'b1; cyc(10); model(); check_all("R5");
      set_ref(1'b0, 1'b0); check_all("R5");
      chk("R5 manual ignores loss", 12'({holdover, sel_b}), 12'd1);
      manual_b = 1'b0; cyc(10); model(); check_all("R5");

      // constrained random mix
      for (int i = 0; i < 40; i++) begin
         int op;
         op = $urandom_range(0, 5);
         case (op)
            0: set_ref(1'b0, !on_a);
            1: set_ref(1'b1, !on_b);
            2: begin auto_mode = !auto_mode; cyc(10); model(); end
            3: begin revertive = !revertive; cyc(10); model(); end
            4: begin prefer_b = !prefer_b; cyc(10); model(); end
            default: begin manual_b = !manual_b; cyc(10); model(); end
         endcase
         check_all(!auto_mode ? "R5" : e_hold ? "R7" : "R6");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule